// File: doc/BRIEF.md
# Victim Block Store for a Direct-Mapped Cache

This block is a small, fully associative buffer of cache lines that a direct-mapped primary cache has recently thrown out. It sits on the primary cache's refill path. Each time the primary cache misses, it presents the missing block address together with the line it is about to overwrite. The store then answers within one cycle, before anything is sent to the next memory level.

On a hit, the stored block goes back to the primary cache. In the same cycle, the outgoing primary line takes over the hit entry, so the two lines trade places. On a miss, the outgoing line is installed and a read request for the missing block is sent downstream. Installation fills an empty entry first. When no entry is empty, it replaces the entry whose current contents arrived earliest. A flush input empties the whole store.

Top module: `victim_cache`

## Requirements
- R1: After reset, no entry is valid, and `respValid`, `respHit`, `memReqValid`, `respData` and `memReqAddr` are all zero.
- R2: A lookup is accepted in a cycle where `lookupValid` is 1. On the next clock edge `respValid` goes to 1 for exactly one cycle, and it stays 0 when no lookup was made.
- R3: On a hit, `respHit` is 1 and `respData` carries the stored block for `lookupAddr`. `respData` is word 0 in bits 31:0, rising to word 3 in bits 127:96. On a hit, `memReqValid` stays 0.
- R4: On a miss, `respHit` is 0 and `respData` is zero. `memReqValid` is 1 for one cycle, with `memReqAddr` equal to the looked-up address.
- R5: On a hit, the hit entry is overwritten with the outgoing address and data. A later lookup of that outgoing address hits, and a later lookup of the old address misses.
- R6: On a miss with a valid outgoing line, the line is written to an empty entry whenever one exists. No valid entry is displaced while an empty one exists.
- R7: With all entries valid, an install on a miss replaces the entry whose contents were written longest ago. Both swaps and installs count as writes.
- R8: When `evictValid` is 0, a miss installs nothing, and a hit leaves the hit entry empty.
- R9: `flush` empties every entry. A lookup in the same cycle as `flush` reports a miss, issues the downstream request and installs nothing.
- R10: An outgoing line offered while `lookupValid` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all entries |
| lookupValid | input | 1 | Primary miss: search the store |
| lookupAddr | input | ADDR_W | Missing block address |
| evictValid | input | 1 | Outgoing primary line is valid |
| evictAddr | input | ADDR_W | Outgoing line block address |
| evictData | input | WORDS*WORD_W | Outgoing line data |
| respValid | output | 1 | Lookup answer present |
| respHit | output | 1 | Lookup found the block |
| respData | output | WORDS*WORD_W | Block returned on a hit |
| memReqValid | output | 1 | Downstream read request |
| memReqAddr | output | ADDR_W | Address of downstream request |

## Verification
The bench runs a single sequence that fills the store, swaps with a valid outgoing line and with an invalid one, and then installs into the hole that the invalid swap leaves. A design that ignored empty entries would lose a live line there. A design that did not count swaps as writes would evict the wrong entry once the store is full. Further directed cases cover the following, each of which would show up as a stray hit on a later probe:
- a flush that also has a lookup in the same cycle;
- an outgoing line offered without a lookup;
- a miss with an invalid outgoing line.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef struct packed {
    logic clearAll;
    logic writeEn;
    logic writeValid;
    logic respLoad;
    logic respHit;
  } vc_ctrl_t;
endpackage

// File: rtl/vc_datapath.sv
module vc_datapath #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int BLOCK_W = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vc_pkg::vc_ctrl_t   ctrl,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic [ADDR_W-1:0]  evictAddr,
  input  logic [BLOCK_W-1:0] evictData,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] validVec,
  output logic               respValid,
  output logic               respHit,
  output logic [BLOCK_W-1:0] respData,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr
);
  logic [ADDR_W-1:0]  tagQ  [ENTRIES];
  logic [BLOCK_W-1:0] dataQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [BLOCK_W-1:0] hitData;

  assign validVec = validQ;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign hitVec[i] = validQ[i] && (tagQ[i] == lookupAddr);
  end

  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitData = hitData | dataQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearAll) validQ <= '0;
    else if (ctrl.writeEn) validQ[wrIdx] <= ctrl.writeValid;
  end

  always_ff @(posedge clk) begin
    if (ctrl.writeEn) begin
      tagQ[wrIdx]  <= evictAddr;
      dataQ[wrIdx] <= evictData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respData    <= '0;
      memReqValid <= 1'b0;
      memReqAddr  <= '0;
    end else begin
      respValid   <= ctrl.respLoad;
      respHit     <= ctrl.respHit;
      respData    <= ctrl.respHit ? hitData : '0;
      memReqValid <= ctrl.respLoad && !ctrl.respHit;
      memReqAddr  <= (ctrl.respLoad && !ctrl.respHit) ? lookupAddr : '0;
    end
  end

  // R8: a write of an invalid outgoing line leaves the slot empty
  a_r8_empty_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.writeEn && !ctrl.writeValid && !ctrl.clearAll) |=> !validQ[$past(wrIdx)]);
  // R5: written entry holds the outgoing address afterwards
  a_r5_tag_written: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.writeEn && ctrl.writeValid && !ctrl.clearAll) |=> (tagQ[$past(wrIdx)] == $past(evictAddr)));
endmodule

// File: rtl/vc_control.sv
module vc_control #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lookupValid,
  input  logic               evictValid,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] validVec,
  output vc_pkg::vc_ctrl_t   ctrl,
  output logic [IDX_W-1:0]   wrIdx
);
  logic [IDX_W-1:0] ordQ [ENTRIES];
  logic [IDX_W-1:0] ordD [ENTRIES];
  logic [IDX_W-1:0] hitIdx, freeIdx;
  logic hitAny, freeAny, lookupGo, insert;

  assign hitAny   = |hitVec;
  assign freeAny  = ~&validVec;
  assign lookupGo = lookupValid && !flush;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitIdx = IDX_W'(i);
  end

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IDX_W'(i);
  end

  assign wrIdx = hitAny ? hitIdx : (freeAny ? freeIdx : ordQ[0]);

  always_comb begin
    ctrl            = '0;
    ctrl.clearAll   = flush;
    ctrl.respLoad   = lookupValid;
    ctrl.respHit    = lookupGo && hitAny;
    ctrl.writeEn    = lookupGo && (hitAny || evictValid);
    ctrl.writeValid = evictValid;
  end

  assign insert = ctrl.writeEn && evictValid;

  always_comb begin
    int pos;
    pos = ENTRIES - 1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ordQ[i] == wrIdx) pos = i;
    for (int i = 0; i < ENTRIES; i++) ordD[i] = ordQ[i];
    if (insert) begin
      for (int i = 0; i < ENTRIES - 1; i++)
        if (i >= pos) ordD[i] = ordQ[i+1];
      ordD[ENTRIES-1] = wrIdx;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n || flush) ordQ[i] <= IDX_W'(i);
      else                 ordQ[i] <= ordD[i];
    end
  end

  // R6: an install never lands on a valid entry while an empty one exists
  a_r6_fill_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.writeEn && !hitAny && freeAny) |-> !validVec[wrIdx]);
  // R9: flush leaves every entry empty
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (validVec == '0));
  // R10: no lookup, no flush: stored state does not change
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!lookupValid && !flush) |=> $stable(validVec));
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  localparam int BLOCK_W = WORD_W * WORDS,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               evictValid,
  input  logic [ADDR_W-1:0]  evictAddr,
  input  logic [BLOCK_W-1:0] evictData,
  output logic               respValid,
  output logic               respHit,
  output logic [BLOCK_W-1:0] respData,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr
);
  vc_pkg::vc_ctrl_t   ctrl;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] hitVec, validVec;

  vc_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk, .rst_n, .flush, .lookupValid, .evictValid,
    .hitVec, .validVec, .ctrl, .wrIdx
  );

  vc_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_dp (
    .clk, .rst_n, .ctrl, .wrIdx, .lookupAddr, .evictAddr, .evictData,
    .hitVec, .validVec, .respValid, .respHit, .respData,
    .memReqValid, .memReqAddr
  );

  // R2: each lookup is answered on the next edge
  a_r2_answer: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> respValid);
  // R2: no answer without a lookup
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !respValid);
  // R4: miss requests the looked-up block downstream
  a_r4_miss_request: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && (flush || !(|hitVec))) |=> (memReqValid && !respHit && memReqAddr == $past(lookupAddr)));
  // R3: hit issues no downstream request
  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && !flush && (|hitVec)) |=> (respHit && !memReqValid));
endmodule

// File: tb/victim_cache_bench.sv
module victim_cache_bench;
  localparam int ADDR_W = 28;
  localparam int BW = 128;

  typedef struct packed {
    logic [7:0] lk;
    logic       ev;
    logic [7:0] ea;
    logic       hit;
    logic [7:0] da;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{8'h10, 1'b1, 8'h01, 1'b0, 8'h00}, // R6 fill e0
    '{8'h11, 1'b1, 8'h02, 1'b0, 8'h00},
    '{8'h12, 1'b1, 8'h03, 1'b0, 8'h00},
    '{8'h13, 1'b1, 8'h04, 1'b0, 8'h00}, // full
    '{8'h02, 1'b1, 8'h20, 1'b1, 8'h02}, // R3 R5 swap
    '{8'h05, 1'b1, 8'h06, 1'b0, 8'h00}, // R7 replaces 01
    '{8'h01, 1'b0, 8'h00, 1'b0, 8'h00}, // R7 01 gone, R8 no install
    '{8'h03, 1'b1, 8'h03, 1'b1, 8'h03}, // probe
    '{8'h20, 1'b0, 8'h00, 1'b1, 8'h20}, // R8 hit empties slot
    '{8'h07, 1'b1, 8'h08, 1'b0, 8'h00}, // R6 fills hole
    '{8'h09, 1'b1, 8'h0A, 1'b0, 8'h00}, // R7 replaces 04
    '{8'h04, 1'b0, 8'h00, 1'b0, 8'h00}, // R7 04 gone
    '{8'h08, 1'b1, 8'h08, 1'b1, 8'h08}, // R6 hole holds 08
    '{8'h06, 1'b1, 8'h06, 1'b1, 8'h06},
    '{8'h0A, 1'b1, 8'h0A, 1'b1, 8'h0A},
    '{8'h03, 1'b1, 8'h03, 1'b1, 8'h03},
    '{8'h0B, 1'b1, 8'h0C, 1'b0, 8'h00}, // R7 replaces 08
    '{8'h08, 1'b0, 8'h00, 1'b0, 8'h00}  // R7 08 gone
  };

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lookupValid = 1'b0, evictValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0, evictAddr = '0;
  logic [BW-1:0] evictData = '0;
  logic respValid, respHit, memReqValid;
  logic [BW-1:0] respData;
  logic [ADDR_W-1:0] memReqAddr;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  victim_cache u_victim_cache (
    .clk, .rst_n, .flush, .lookupValid, .lookupAddr, .evictValid,
    .evictAddr, .evictData, .respValid, .respHit, .respData,
    .memReqValid, .memReqAddr
  );

  function automatic logic [BW-1:0] blk(input logic [7:0] a);
    logic [BW-1:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = 32'hC0DE_0000 | (32'(a) << 4) | 32'(w);
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] lk, input logic ev, input logic [7:0] ea, input logic fl, input logic lv);
    @(negedge clk);
    lookupValid = lv; lookupAddr = ADDR_W'(lk);
    evictValid = ev; evictAddr = ADDR_W'(ea); evictData = blk(ea);
    flush = fl;
    @(negedge clk);
    lookupValid = 1'b0; evictValid = 1'b0; flush = 1'b0;
  endtask

  task automatic expectResp(input logic [7:0] lk, input logic hit, input logic [7:0] da, input string req);
    chk(respValid == 1'b1, {req, " respValid"}, BW'(respValid), BW'(1));
    chk(respHit == hit, {req, " respHit"}, BW'(respHit), BW'(hit));
    chk(respData == (hit ? blk(da) : '0), {req, " respData"}, respData, hit ? blk(da) : '0);
    chk(memReqValid == !hit, {req, " memReqValid"}, BW'(memReqValid), BW'(!hit));
    chk(memReqAddr == (hit ? '0 : ADDR_W'(lk)), {req, " memReqAddr"}, BW'(memReqAddr), BW'(hit ? 8'h00 : lk));
  endtask

  // probe: hit returns the same block so the store is unchanged
  task automatic probe(input logic [7:0] a, input logic hit, input string req);
    op(a, hit, a, 1'b0, 1'b1);
    expectResp(a, hit, a, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!respValid && !respHit && !memReqValid, "R1 flags", BW'({respValid, respHit, memReqValid}), '0);
    chk(respData == '0 && memReqAddr == '0, "R1 data", respData, '0);
    rst_n = 1'b1;
    @(negedge clk);
    probe(8'h10, 1'b0, "R1 empty");

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].lk, VEC[i].ev, VEC[i].ea, 1'b0, 1'b1);
      expectResp(VEC[i].lk, VEC[i].hit, VEC[i].da, $sformatf("R3/R4/R5/R6/R7 vec%0d", i));
    end
    // R5: old address of swapped block is gone
    probe(8'h02, 1'b0, "R5 old addr");

    // R2: answer lasts one cycle
    @(negedge clk);
    chk(respValid == 1'b0 && memReqValid == 1'b0, "R2 one cycle", BW'(respValid), '0);

    // R10: offer without lookup ignored
    op(8'h00, 1'b1, 8'h55, 1'b0, 1'b0);
    chk(respValid == 1'b0, "R10 no answer", BW'(respValid), '0);
    probe(8'h55, 1'b0, "R10 not installed");

    // R9: lookup during flush misses, installs nothing, store emptied
    op(8'h06, 1'b1, 8'h66, 1'b1, 1'b1);
    expectResp(8'h06, 1'b0, 8'h00, "R9 flush lookup");
    probe(8'h66, 1'b0, "R9 nothing installed");
    probe(8'h03, 1'b0, "R9 emptied");

    // R8: miss with invalid outgoing line installs nothing
    op(8'h30, 1'b0, 8'h31, 1'b0, 1'b1);
    expectResp(8'h30, 1'b0, 8'h00, "R8 miss");
    probe(8'h31, 1'b0, "R8 nothing installed");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule